// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive Control

This block decides, cycle by cycle, whether the 4-bit data pins of an extended-data-out DRAM are driven or left at high impedance, and which value they carry. The active-low row strobe, column strobe, write enable and output enable are sampled on a system clock. A falling column strobe during a read captures the array's read data into an output register.

Unlike a plain page-mode part, the pins keep driving after the column strobe rises. The system can latch the word while the next column is already being decoded. There are two ways to turn the pins off during column-strobe-high time:

- the output enable is held high across the column strobe rise for a minimum number of clocks, or
- it pulses high for a minimum number of clocks after a rise that happened with it low.

Once off, the pins stay off until the column strobe falls again. A write, or the end of the row cycle, also turns them off.

Top module: `edo_oe_ctrl`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released with all strobes high, dq_oe_o is 0 and dq_o is 0.
- R2: A sample in which cas_ni falls (high at the previous sample, low now) with ras_ni low and we_ni high loads rd_data_i into dq_o. dq_o presents it after that clock edge, and dq_oe_o is 1 if oe_ni is low at that sample.
- R3: In a read, while no disable condition holds, dq_oe_o follows the inverse of oe_ni on each sample: oe_ni high gives 0 and oe_ni low gives 1.
- R4: dq_o changes only on a column-strobe fall. After cas_ni rises with oe_ni low, the pins keep driving the same word even though rd_data_i changes.
- R5: Suppose oe_ni is high at the sample before cas_ni rises and stays high for k consecutive samples, counting the rise sample. If k is at least HOLD_CYC, the pins stay off after oe_ni returns low. If k is smaller, they drive again.
- R6: Suppose cas_ni rises with oe_ni low, and oe_ni is then high for k consecutive samples while cas_ni is high. If k is at least PULSE_CYC, the pins stay off after oe_ni returns low. If k is smaller, they drive again.
- R7: Once disabled by R5 or R6, oe_ni low has no effect until cas_ni falls. That fall clears the disable, and the pins drive again when oe_ni is low.
- R8: A sample with cas_ni low and we_ni low forces dq_oe_o to 0 until a later column-strobe fall with we_ni high.
- R9: Any sample with ras_ni and cas_ni both high gives dq_oe_o 0. In the next row cycle the pins stay off until a read column-strobe fall.
- R10: A column-strobe fall with ras_ni high loads no data and does not enable the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all strobes sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_data_i | input | DW | Word read from the array for the current column |
| dq_o | output | DW | Output register value |
| dq_oe_o | output | 1 | Drive enable for the data pins |

## Verification
The bench sweeps the OE high time across each threshold, from one clock up to two past it, for both disable methods. A counter that is off by one turns the pins off one width too early or too late, and that shows at exactly one sweep step. A design that confuses the two methods applies the wrong threshold and also fails at a boundary step. After each disable the bench drives OE low and checks that the pins stay off, then drops CAS and checks that they come back. A latch that is not cleared, or a gate on OE that is too weak, fails there. Separate sequences cover three cases: a write that would otherwise leak read data, a column-strobe fall without the row strobe that must not load, and a new row cycle that must not drive stale data.

// File: rtl/edo_oe_pkg.sv
package edo_oe_pkg;
  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_ni,
  input  logic oe_ni,
  output logic cas_rise_o,
  output logic cas_fall_o,
  output logic oe_hi_prev_o
);
  logic cas_p_q, oe_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_p_q <= 1'b1;
      oe_p_q  <= 1'b1;
    end else begin
      cas_p_q <= cas_ni;
      oe_p_q  <= oe_ni;
    end
  end

  assign cas_rise_o   = !cas_p_q && cas_ni;
  assign cas_fall_o   = cas_p_q && !cas_ni;
  assign oe_hi_prev_o = oe_p_q;
endmodule

// File: rtl/edo_disable_ctl.sv
module edo_disable_ctl #(
  parameter int unsigned HOLD_CYC  = 3,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_hi_i,
  input  logic oe_hi_i,
  input  logic oe_hi_prev_i,
  input  logic cas_rise_i,
  input  logic cas_fall_i,
  output logic dis_next_o
);
  import edo_oe_pkg::*;
  localparam int unsigned MAXT = max_u(max_u(HOLD_CYC, PULSE_CYC), 1);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q, cnt_n, thr;
  logic          hold_q, hold_n;
  logic          dis_q, dis_n;

  // one run counter serves both methods; mode picks the threshold
  always_comb begin
    cnt_n  = '0;
    hold_n = hold_q;
    if (cas_hi_i && oe_hi_i) begin
      if (cas_rise_i) begin
        hold_n = oe_hi_prev_i;
        cnt_n  = CW'(1);
      end else if (oe_hi_prev_i) begin
        cnt_n = (cnt_q == CW'(MAXT)) ? cnt_q : cnt_q + CW'(1);
      end else begin
        hold_n = 1'b0;
        cnt_n  = CW'(1);
      end
    end
    thr = hold_n ? CW'(HOLD_CYC) : CW'(PULSE_CYC);
    if (cas_fall_i) dis_n = 1'b0;
    else            dis_n = dis_q || (cas_hi_i && oe_hi_i && (cnt_n >= thr));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
      dis_q  <= dis_n;
    end
  end

  assign dis_next_o = dis_n;
endmodule

// File: rtl/edo_dout_path.sv
module edo_dout_path #(
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          cas_fall_i,
  input  logic          dis_next_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic [DW-1:0] dout_q;
  logic          valid_q, valid_n;
  logic          wr_q, wr_n;
  logic          oe_q, oe_n;
  logic          rd_fall, end_cycle;

  assign rd_fall   = cas_fall_i && !ras_ni && we_ni;
  assign end_cycle = ras_ni && cas_ni;

  always_comb begin
    if (end_cycle)    valid_n = 1'b0;
    else if (rd_fall) valid_n = 1'b1;
    else              valid_n = valid_q;

    if (cas_fall_i) wr_n = !we_ni;
    else            wr_n = wr_q || (!cas_ni && !we_ni);

    oe_n = valid_n && !dis_next_i && !wr_n && !oe_ni && !end_cycle;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (rd_fall) dout_q <= rd_data_i;
      valid_q <= valid_n;
      wr_q    <= wr_n;
      oe_q    <= oe_n;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/edo_oe_ctrl.sv
module edo_oe_ctrl #(
  parameter int unsigned DW        = 4,
  parameter int unsigned HOLD_CYC  = 3,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic cas_rise, cas_fall, oe_hi_prev, dis_next;

  edo_strobe_edge i_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cas_ni      (cas_ni),
    .oe_ni       (oe_ni),
    .cas_rise_o  (cas_rise),
    .cas_fall_o  (cas_fall),
    .oe_hi_prev_o(oe_hi_prev)
  );

  edo_disable_ctl #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) i_dis (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cas_hi_i    (cas_ni),
    .oe_hi_i     (oe_ni),
    .oe_hi_prev_i(oe_hi_prev),
    .cas_rise_i  (cas_rise),
    .cas_fall_i  (cas_fall),
    .dis_next_o  (dis_next)
  );

  edo_dout_path #(.DW(DW)) i_dout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .cas_fall_i(cas_fall),
    .dis_next_i(dis_next),
    .rd_data_i (rd_data_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );
endmodule

// File: rtl/edo_oe_ctrl_chk.sv
module edo_oe_ctrl_chk #(
  parameter int unsigned DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_ni,
  input logic          cas_ni,
  input logic          we_ni,
  input logic          oe_ni,
  input logic [DW-1:0] rd_data_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o
);
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= '0;
    else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
  end

  p_oe_high_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd1 && $past(oe_ni)) |-> !dq_oe_o);

  p_data_stable_cas_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd1 && $past(cas_ni)) |-> (dq_o == $past(dq_o)));

  p_write_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd1 && $past(!cas_ni && !we_ni)) |-> !dq_oe_o);

  p_idle_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd1 && $past(ras_ni && cas_ni)) |-> !dq_oe_o);

  p_read_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2 && $past(cas_ni, 2) && $past(!cas_ni && !ras_ni && we_ni))
      |-> (dq_o == $past(rd_data_i)));
endmodule

bind edo_oe_ctrl edo_oe_ctrl_chk #(.DW(DW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ras_ni   (ras_ni),
  .cas_ni   (cas_ni),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .rd_data_i(rd_data_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o)
);

// File: tb/test_edo_oe_ctrl.sv
module test_edo_oe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int HOLD = 3;
  localparam int PULSE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [DW-1:0] rd = '0;
  logic [DW-1:0] dq;
  logic dq_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_oe_ctrl #(.DW(DW), .HOLD_CYC(HOLD), .PULSE_CYC(PULSE)) i_edo_oe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .cas_ni(cas), .we_ni(we),
    .oe_ni(oe), .rd_data_i(rd), .dq_o(dq), .dq_oe_o(dq_oe));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_oe(string req, logic exp);
    n_chk++;
    if (dq_oe !== exp) begin
      n_fail++;
      $display("FAIL %s dq_oe_o actual=%b expected=%b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_dq(string req, logic [DW-1:0] exp);
    n_chk++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s dq_o actual=%h expected=%h", req, dq, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    #(CLK_PERIOD*2 + 1);
    chk_oe("R1", 1'b0); chk_dq("R1", '0);
    rst_n = 1'b1;
    tick();
    chk_oe("R1", 1'b0); chk_dq("R1", '0);

    // R5 sweep: OE high across the CAS rise
    for (int k = 1; k <= HOLD + 2; k++) begin
      d = DW'(k*5 + 3);
      oe = 1'b0; ras = 1'b0; tick();
      chk_oe("R9", 1'b0);
      rd = d; cas = 1'b0; tick();
      chk_dq("R2", d); chk_oe("R2", 1'b1);
      oe = 1'b1; tick();
      chk_oe("R3", 1'b0);
      cas = 1'b1; rd = ~d; tick();
      for (int j = 1; j < k; j++) tick();
      oe = 1'b0; tick();
      chk_oe("R5", k < HOLD); chk_dq("R4", d);
      tick();
      chk_oe("R7", k < HOLD);
      rd = DW'(d + 1); cas = 1'b0; tick();
      chk_oe("R7", 1'b1); chk_dq("R2", DW'(d + 1));
      ras = 1'b1; cas = 1'b1; tick();
      chk_oe("R9", 1'b0);
    end

    // R6 sweep: OE pulse during CAS high
    for (int k = 1; k <= PULSE + 2; k++) begin
      d = DW'(k*7 + 2);
      oe = 1'b0; ras = 1'b0; rd = d; cas = 1'b0; tick();
      chk_oe("R2", 1'b1); chk_dq("R2", d);
      cas = 1'b1; rd = ~d; tick();
      chk_oe("R4", 1'b1); chk_dq("R4", d);
      oe = 1'b1;
      for (int j = 0; j < k; j++) tick();
      chk_oe("R3", 1'b0);
      oe = 1'b0; tick();
      chk_oe("R6", k < PULSE); chk_dq("R4", d);
      cas = 1'b0; tick();
      chk_oe("R7", 1'b1); chk_dq("R2", ~d);
      ras = 1'b1; cas = 1'b1; tick();
      chk_oe("R9", 1'b0);
    end

    // R3: OE toggling while CAS low
    ras = 1'b0; rd = 4'h9; cas = 1'b0; tick();
    chk_oe("R3", 1'b1);
    oe = 1'b1; tick(); chk_oe("R3", 1'b0);
    oe = 1'b0; tick(); chk_oe("R3", 1'b1); chk_dq("R3", 4'h9);
    ras = 1'b1; cas = 1'b1; tick();

    // R8: write forces off
    ras = 1'b0; tick();
    rd = 4'h6; we = 1'b0; cas = 1'b0; tick();
    chk_oe("R8", 1'b0); chk_dq("R8", 4'h9);
    we = 1'b1; tick(); chk_oe("R8", 1'b0);
    cas = 1'b1; tick(); chk_oe("R8", 1'b0);
    cas = 1'b0; tick(); chk_oe("R8", 1'b1); chk_dq("R8", 4'h6);
    ras = 1'b1; cas = 1'b1; tick(); chk_oe("R9", 1'b0);

    // R10: CAS fall without RAS
    rd = 4'hC; cas = 1'b0; tick();
    chk_oe("R10", 1'b0); chk_dq("R10", 4'h6);
    cas = 1'b1; tick(); chk_oe("R10", 1'b0);
    ras = 1'b0; tick(); chk_oe("R9", 1'b0);
    ras = 1'b1; tick();

    done = 1;
    finish_run();
  end
endmodule